// File: doc/BRIEF.md
# Endian-Aware Bus Width Adapter

This block connects an internal 32-bit access port to an external memory bus whose device can be 8, 16 or 32 bits wide. The requester issues one request with an address, an access size, a direction and write data. The adapter splits the request into as many external bus cycles as the device width requires. It places each byte on the correct byte lane for the byte order chosen at power-on reset. For reads, it gathers the returned bytes into one right-justified result. The requester sees a single completion pulse, whatever the device width.

The byte order comes from a mode pin and is captured only while reset is asserted. After reset is released, a settling counter runs. No bus cycle can begin until that counter is full. This gives slow devices time to recover from reset before their first access.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst` is high, `mode_pin` is sampled: 0 selects big endian and 1 selects little endian. Changes on `mode_pin` after reset is released have no effect until the next reset.
- R2: After reset is released, a 7-bit counter counts from 0 up to 127 and then stops. `ext_valid` stays low until the counter has reached 127. A request held from the moment of release produces its first bus cycle right after the 128th rising edge.
- R3: Size codes are 0 = byte, 1 = word and 2 = longword. Width codes are 0 = 8, 1 = 16 and 2 = 32 bits. One request produces max(1, N/W) bus cycles, where N is the access size in bytes and W is the device width in bytes.
- R4: The bus cycles of one request are issued in ascending address order. The first cycle uses the request address, and each later cycle adds W.
- R5: A byte at address A is carried on lane (A mod W) in little endian and on lane (W-1-(A mod W)) in big endian. Lane k is `ext_wdata[8k+7:8k]`. `ext_be` bit k marks lane k as used. On writes, unused lanes carry zero, and `ext_write` matches the request direction.
- R6: When an access is split, the first cycle carries the most significant part of the data in big endian and the least significant part in little endian.
- R7: A read returns the assembled value right-justified in `req_rdata`, with the bits above the access size cleared. Data on lanes that are not enabled is ignored.
- R8: During a bus cycle, `ext_addr`, `ext_be` and `ext_wdata` hold steady until `ext_ready` is sampled high. `req_done` is a one-cycle pulse in the cycle after the last ready.
- R9: A request is taken only when the adapter is idle and settled. A request raised earlier waits, and it is not lost.
- R10: Lanes at or above the device width are never enabled. Each bus cycle enables exactly min(N, W) lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_pin | input | 1 | Byte-order strap, sampled during reset |
| dev_width | input | 2 | Device width code |
| req_valid | input | 1 | Request present, held until `req_done` |
| req_addr | input | 32 | Request byte address, aligned to the size |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Right-justified read result, valid with `req_done` |
| ext_valid | output | 1 | External bus cycle active |
| ext_addr | output | 32 | Byte address of the current bus cycle |
| ext_write | output | 1 | Direction of the current bus cycle |
| ext_be | output | 4 | Byte lane enables |
| ext_wdata | output | 32 | Lane-steered write data |
| ext_rdata | input | 32 | Lane data returned by the device |
| ext_ready | input | 1 | Completes the current bus cycle |

## Verification
The checks take for granted that the requester keeps its address, size, direction and data steady from acceptance until `req_done`, and that it drops `req_valid` in the cycle `req_done` is high. They also assume that `dev_width` stays constant while a request is in flight, that size and width codes never exceed 2, and that every address is naturally aligned. Finally, they assume that `ext_ready` is raised only while `ext_valid` is high. The stimulus obeys all of these. It drives requests from a task that waits for completion before starting the next one. It chooses only aligned addresses from code loops limited to 0..2. It changes `dev_width` only between requests. Its device model raises ready only during a bus cycle, after a chosen number of wait cycles.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size_log;
        logic [1:0]        width_log;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // log2 of the bytes moved per bus cycle
    function automatic logic [1:0] chunk_log2(input logic [1:0] size_log,
                                              input logic [1:0] width_log);
        return (size_log < width_log) ? size_log : width_log;
    endfunction

    // log2 of the number of bus cycles per request
    function automatic logic [1:0] split_log2(input logic [1:0] size_log,
                                              input logic [1:0] width_log);
        return (size_log > width_log) ? 2'(size_log - width_log) : 2'd0;
    endfunction

    // 2**n - 1 for n in 0..2
    function automatic logic [1:0] pow_mask(input logic [1:0] n);
        case (n)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/bwa_settle.sv
module bwa_settle #(
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst,
    output logic settled
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign settled = (cnt == CNT_MAX);
endmodule

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
    import bwa_pkg::*;
(
    input  logic                  endian_le,
    input  logic [1:0]            width_log,
    input  logic [1:0]            chunk_log,
    input  logic [1:0]            start,
    input  logic [1:0]            chunk_idx,
    output logic [LANES-1:0]      lane_en,
    output logic [LANES-1:0][1:0] lane_byte
);
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        int   w, b, s, o, idx;
        logic en_l;
        logic [1:0] byte_l;

        always_comb begin
            w    = 1 << width_log;
            b    = 1 << chunk_log;
            s    = int'(start);
            // device-relative byte offset served by this lane
            o    = endian_le ? L : (w - 1 - L);
            en_l = (L < w) && (o >= s) && (o < s + b);
            idx  = (int'(chunk_idx) << chunk_log)
                 + (endian_le ? (o - s) : (s + b - 1 - o));
            byte_l = idx[1:0];
        end

        assign lane_en[L]   = en_l;
        assign lane_byte[L] = byte_l;
    end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int SETTLE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pin,
    input  logic [1:0]        dev_width,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [DATA_W-1:0] req_rdata,
    output logic              ext_valid,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_write,
    output logic [LANES-1:0]  ext_be,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready
);
    seq_state_e  state;
    xfer_t       cur;
    logic [1:0]  beat;
    logic [DATA_W-1:0] acc;
    logic        endian_le;
    logic        settled;

    logic [1:0]  chunk_log, nb_m1, chunk_idx, start;
    logic        last_beat;
    logic [ADDR_W-1:0] beat_addr;
    logic [LANES-1:0]       lane_en;
    logic [LANES-1:0][1:0]  lane_byte;

    // byte order strap, captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst)
            endian_le <= mode_pin;
    end

    bwa_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .settled (settled)
    );

    always_comb begin
        chunk_log = chunk_log2(cur.size_log, cur.width_log);
        nb_m1     = pow_mask(split_log2(cur.size_log, cur.width_log));
        last_beat = (beat == nb_m1);
        chunk_idx = endian_le ? beat : 2'(nb_m1 - beat);
        beat_addr = cur.addr + ({{(ADDR_W-2){1'b0}}, beat} << cur.width_log);
        start     = beat_addr[1:0] & pow_mask(cur.width_log);
    end

    bwa_lane_map u_lane (
        .endian_le (endian_le),
        .width_log (cur.width_log),
        .chunk_log (chunk_log),
        .start     (start),
        .chunk_idx (chunk_idx),
        .lane_en   (lane_en),
        .lane_byte (lane_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            beat  <= '0;
            acc   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (settled && req_valid) begin
                        cur.addr      <= req_addr;
                        cur.size_log  <= req_size;
                        cur.width_log <= dev_width;
                        cur.write     <= req_write;
                        cur.wdata     <= req_wdata;
                        beat          <= '0;
                        acc           <= '0;
                        state         <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (ext_ready) begin
                        if (!cur.write) begin
                            for (int L = 0; L < LANES; L++) begin
                                if (lane_en[L])
                                    acc[8*lane_byte[L] +: 8] <= ext_rdata[8*L +: 8];
                            end
                        end
                        if (last_beat)
                            state <= ST_DONE;
                        else
                            beat <= beat + 2'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ext_valid = (state == ST_BUS);
    assign ext_addr  = beat_addr;
    assign ext_write = cur.write;
    assign ext_be    = ext_valid ? lane_en : '0;

    for (genvar L = 0; L < LANES; L++) begin : g_wlane
        assign ext_wdata[8*L +: 8] = (ext_valid && lane_en[L])
                                   ? cur.wdata[8*lane_byte[L] +: 8] : 8'h00;
    end

    assign req_done  = (state == ST_DONE);
    assign req_rdata = acc;
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
    import bwa_pkg::*;
#(
    parameter int SETTLE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        req_size,
    input logic [1:0]        dev_width,
    input logic              req_done,
    input logic              ext_valid,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [LANES-1:0]  ext_be,
    input logic [DATA_W-1:0] ext_wdata,
    input logic              ext_ready,
    input logic              endian_le
);
    localparam int SINCE_MAX = 1 << SETTLE_W;

    // cycles since reset release, saturating one past the settle limit
    logic [SETTLE_W:0] since;
    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (int'(since) != SINCE_MAX)
            since <= since + 1'b1;
    end

    p_no_early_bus_r2: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> (int'(since) == SINCE_MAX));

    p_order_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> $stable(endian_le));

    p_hold_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr)
                                       && $stable(ext_be) && $stable(ext_wdata)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    p_done_after_ready_r8: assert property (@(posedge clk) disable iff (rst)
        req_done |-> ($past(ext_ready) && !ext_valid));

    p_lane_count_r10: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> ($countones(ext_be) == (1 << chunk_log2(req_size, dev_width))));

    p_lane_range_r10: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> ((ext_be >> (1 << dev_width)) == '0));
endmodule

bind bus_width_adapter bwa_checker #(.SETTLE_W(SETTLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_size  (req_size),
    .dev_width (dev_width),
    .req_done  (req_done),
    .ext_valid (ext_valid),
    .ext_addr  (ext_addr),
    .ext_be    (ext_be),
    .ext_wdata (ext_wdata),
    .ext_ready (ext_ready),
    .endian_le (endian_le)
);

// File: tb/bus_width_adapter_test.sv
module bus_width_adapter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, mode_pin;
    logic [1:0]  dev_width;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic        req_done;
    logic [31:0] req_rdata;
    logic        ext_valid, ext_write;
    logic [31:0] ext_addr, ext_wdata, ext_rdata;
    logic [3:0]  ext_be;
    logic        ext_ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic tb_le = 1'b0;
    int   dw_bytes;
    logic [7:0] mem [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_width_adapter uut (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .dev_width(dev_width),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata),
        .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_write(ext_write),
        .ext_be(ext_be), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    // device model: every lane of the device drives its byte, upper lanes junk
    assign dw_bytes = 1 << dev_width;
    always_comb begin
        for (int L = 0; L < 4; L++) begin
            if (L < dw_bytes)
                ext_rdata[8*L +: 8] = mem[6'((int'(ext_addr) & ~(dw_bytes - 1))
                                        + (tb_le ? L : dw_bytes - 1 - L))];
            else
                ext_rdata[8*L +: 8] = 8'hEE;
        end
    end

    task automatic chk(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; mode_pin = strap; req_valid = 1'b0; ext_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ext_valid && !req_done, "R2 reset state idle",
            {30'd0, ext_valid, req_done}, 32'd0);
        rst = 1'b0;
        mode_pin = ~strap;   // R1: must be ignored from here on
    endtask

    task automatic run_access(input int addr, input int sz, input logic wr,
                              input logic [31:0] wd, input int waits);
        int n, w, nb;
        logic [3:0]  e_be [4];
        logic [31:0] e_wd [4];
        logic [31:0] e_rd;
        n = 1 << sz; w = 1 << dev_width;
        nb = (n > w) ? n / w : 1;
        for (int k = 0; k < 4; k++) begin e_be[k] = '0; e_wd[k] = '0; end
        e_rd = '0;
        for (int i = 0; i < n; i++) begin
            int a, k, lane, db;
            a    = addr + i;
            k    = (nb > 1) ? i / w : 0;
            lane = tb_le ? (a % w) : (w - 1 - (a % w));
            db   = tb_le ? i : (n - 1 - i);
            e_be[k][lane] = 1'b1;
            e_wd[k][8*lane +: 8] = wd[8*db +: 8];
            e_rd[8*db +: 8] = mem[6'(a)];
        end
        req_addr = 32'(addr); req_size = 2'(sz); req_write = wr;
        req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k < nb; k++) begin
            for (int q = 0; q <= waits; q++) begin
                @(negedge clk);
                chk(ext_valid, "R3 bus cycle present", {31'd0, ext_valid}, 32'd1);
                chk(ext_addr == 32'(addr + k * w), "R4 cycle address",
                    ext_addr, 32'(addr + k * w));
                chk(ext_be == e_be[k], "R5 R10 lane enables",
                    {28'd0, ext_be}, {28'd0, e_be[k]});
                chk(ext_write == wr, "R5 direction", {31'd0, ext_write}, {31'd0, wr});
                if (wr)
                    chk(ext_wdata == e_wd[k], "R6 R5 steered write data",
                        ext_wdata, e_wd[k]);
                ext_ready = (q == waits);
                @(posedge clk);
            end
        end
        @(negedge clk);
        ext_ready = 1'b0;
        chk(req_done && !ext_valid, "R8 done after last ready",
            {30'd0, req_done, ext_valid}, 32'd2);
        if (!wr)
            chk(req_rdata == e_rd, "R7 R1 read result", req_rdata, e_rd);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!req_done && !ext_valid, "R8 R3 single completion",
            {30'd0, req_done, ext_valid}, 32'd0);
    endtask

    task automatic battery();
        for (int dw = 0; dw < 3; dw++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int v = 0; v < 2; v++) begin
                    int addr;
                    logic [31:0] wd;
                    dev_width = 2'(dw);
                    addr = (16 + 8 * v + ((dw * 3 + sz + v * 2) % 4)) & ~((1 << sz) - 1);
                    wd   = 32'hA1B2C3D4 ^ 32'(dw * 4099 + sz * 257 + v * 17);
                    run_access(addr, sz, 1'b1, wd, (dw + v) % 3);
                    run_access(addr, sz, 1'b0, 32'hFFFF_FFFF, (sz + v) % 2);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int first;
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
        dev_width = 2'd2; req_addr = '0; req_size = 2'd2; req_write = 1'b0;
        req_wdata = '0;

        // big endian strap; request raised at release waits for settling (R2, R9)
        tb_le = 1'b0;
        do_reset(1'b0);
        req_addr = 32'd8; req_size = 2'd2; req_write = 1'b0; req_valid = 1'b1;
        first = 0;
        for (int c = 1; c < 300; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (ext_valid) begin first = c; break; end
        end
        chk(first == 128, "R2 R9 first bus cycle edge", 32'(first), 32'd128);
        chk(ext_addr == 32'd8, "R9 pending request kept", ext_addr, 32'd8);
        ext_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_ready = 1'b0;
        chk(req_rdata == {mem[8], mem[9], mem[10], mem[11]}, "R1 R7 big endian long",
            req_rdata, {mem[8], mem[9], mem[10], mem[11]});
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        battery();

        // little endian strap
        tb_le = 1'b1;
        do_reset(1'b1);
        repeat (130) @(posedge clk);
        @(negedge clk);
        chk(!ext_valid, "R9 idle without request", {31'd0, ext_valid}, 32'd0);
        battery();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule